// File: doc/BRIEF.md
# Vectored Critical Interrupt Controller

This block gathers 32 interrupt request lines into one status register. Each line can be set up to latch on a rising edge or to follow its level. Pending sources that are enabled are split by a per-source selection mask between two processor-facing outputs, a normal request and a critical request. Software reaches the block through a simple word-addressed register port with nine locations. Writes take effect on the next clock edge. Reads are combinational from the current address.

For the critical path the block also forms a vector address. It picks the first pending critical source in a scan whose direction software chooses. The vector is a programmable base plus 512 bytes for each step that source lies from the start of the scan. A polarity word is kept only so that software can read it back. A build parameter removes the vector function, and both of its addresses then read as zero.

Top module: `crit_vec_intc`

## Requirements
- R1: Word addresses 0 to 8 map as: 0 status, 1 status-set, 2 enable, 3 critical-select, 4 polarity, 5 trigger-type, 6 masked-status, 7 vector, 8 vector-config. Enable, critical-select and trigger-type read back what was written. Reads of addresses 0 and 1 both return status, and address 6 returns status AND enable.
- R2: Input `irq_in[n]` owns status bit 31-n. When trigger-type bit 31-n is 1, a rising input (low on the previous clock, high now) sets the bit. A falling input or a steady high input leaves the bit alone.
- R3: When trigger-type bit 31-n is 0, the status bit takes the new input value on the clock after any change of `irq_in[n]`.
- R4: A write to address 1 ORs the written data into status.
- R5: A write to address 0 clears every status bit that is written as 1, except for level-type sources whose input is high, which stay set. If an edge-type source rises in the same cycle as the clear, its bit is set.
- R6: `irq_norm` is high exactly when status AND enable AND NOT critical-select is nonzero. `irq_crit` is high exactly when status AND enable AND critical-select is nonzero.
- R7: When vector-config bit 0 is 0, the vector is (vector-config with bits 1:0 cleared) + 512*i, where i is the lowest set bit index of the pending critical set.
- R8: When vector-config bit 0 is 1, the vector is the same base + 512*(31-i), where i is the highest set bit index of the pending critical set.
- R9: Vector-config bit 1 always reads back as 0. The vector reads 0 whenever no critical source is pending.
- R10: Writes to addresses 6, 7 and to any address above 8 change no register.
- R11: Reset clears status, enable, critical-select, polarity, trigger-type, vector-config and vector, and drives both outputs low.
- R12: With the vector parameter off, addresses 7 and 8 read as 0.
- R13: The polarity word at address 4 is stored and read back and has no effect on any other behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Interrupt request lines; line n maps to status bit 31-n |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register word address for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| irq_norm | output | 1 | Normal interrupt request |
| irq_crit | output | 1 | Critical interrupt request |

## Verification
A status update from a software write and a status update from an input line can land on the same clock edge. The sharpest case is a clear written to an edge-type bit in the same cycle as that line rises. The bench drives the rising input and the clear write from the same falling edge. It then expects the bit to read as set, because the new edge must not be lost. The second overlap is a clear that targets a level-type source whose input is still high. The bench expects that bit to survive the write.

// File: rtl/crit_vec_intc.sv
module crit_vec_intc #(
  parameter int NSRC       = 32,
  parameter bit HAS_VEC    = 1'b1,
  parameter int AW         = 4,
  parameter int VSTEP_LOG2 = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_in,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [NSRC-1:0] wdata,
  output logic [NSRC-1:0] rdata,
  output logic            irq_norm,
  output logic            irq_crit
);
  localparam int IW = $clog2(NSRC);

  logic [NSRC-1:0] stat_q, en_q, crit_q, pol_q, trig_q, vcfg_q, prev_q;
  logic [NSRC-1:0] lvl_m, rise, chg, base_s, stat_d;
  logic [NSRC-1:0] pend_c, scan, vec;
  logic [IW-1:0]   idx;

  for (genvar g = 0; g < NSRC; g++) begin : g_map
    assign lvl_m[NSRC-1-g] = irq_in[g];
    assign scan[g] = vcfg_q[0] ? pend_c[NSRC-1-g] : pend_c[g];
  end

  wire wr_clr = wr_en && (addr == AW'(0));
  wire wr_set = wr_en && (addr == AW'(1));

  assign rise = lvl_m & ~prev_q;
  assign chg  = lvl_m ^ prev_q;

  always_comb begin
    if (wr_clr)      base_s = (stat_q & ~wdata) | (lvl_m & ~trig_q);
    else if (wr_set) base_s = stat_q | wdata;
    else             base_s = stat_q;
  end

  assign stat_d = (trig_q & (base_s | rise))
                | (~trig_q & ((chg & lvl_m) | (~chg & base_s)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
      crit_q <= '0;
      pol_q  <= '0;
      trig_q <= '0;
      vcfg_q <= '0;
      prev_q <= '0;
    end else begin
      stat_q <= stat_d;
      prev_q <= lvl_m;
      if (wr_en) begin
        case (addr)
          AW'(2): en_q   <= wdata;
          AW'(3): crit_q <= wdata;
          AW'(4): pol_q  <= wdata;
          AW'(5): trig_q <= wdata;
          AW'(8): vcfg_q <= wdata & ~NSRC'(2);
          default: ;
        endcase
      end
    end
  end

  assign pend_c   = stat_q & en_q & crit_q;
  assign irq_crit = |pend_c;
  assign irq_norm = |(stat_q & en_q & ~crit_q);

  always_comb begin
    idx = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (scan[i]) idx = IW'(i);
  end

  assign vec = (HAS_VEC && irq_crit)
             ? ((vcfg_q & ~NSRC'(3)) + (NSRC'(idx) << VSTEP_LOG2))
             : '0;

  always_comb begin
    case (addr)
      AW'(0), AW'(1): rdata = stat_q;
      AW'(2):         rdata = en_q;
      AW'(3):         rdata = crit_q;
      AW'(4):         rdata = pol_q;
      AW'(5):         rdata = trig_q;
      AW'(6):         rdata = stat_q & en_q;
      AW'(7):         rdata = vec;
      AW'(8):         rdata = HAS_VEC ? vcfg_q : '0;
      default:        rdata = '0;
    endcase
  end

  a_r2_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & $past(rise & trig_q)) == $past(rise & trig_q)));

  a_r5_clear_keeps_level: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((stat_q & $past(lvl_m & ~trig_q)) == $past(lvl_m & ~trig_q)));

  a_r4_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((stat_q & $past(wdata & trig_q)) == $past(wdata & trig_q)));

  if (HAS_VEC) begin : g_vchk
    a_r9_vec_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_crit |-> (vec == '0));
    a_r7_vec_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
      irq_crit |-> (vec[VSTEP_LOG2-1:0] == {vcfg_q[VSTEP_LOG2-1:2], 2'b00}));
  end
endmodule

// File: tb/crit_vec_intc_tb_top.sv
`timescale 1ns/1ps
module crit_vec_intc_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata_nv;
  logic        irq_norm, irq_crit, nv_norm, nv_crit;
  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  crit_vec_intc dut_i (.clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_norm(irq_norm), .irq_crit(irq_crit));

  crit_vec_intc #(.HAS_VEC(1'b0)) dut_nv (.clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata_nv),
    .irq_norm(nv_norm), .irq_crit(nv_crit));

  // {req, write addr, write data, read addr, expected}
  localparam logic [75:0] TBL [16] = '{
    {4'd1,  4'd2, 32'h8000FFFF, 4'd2, 32'h8000FFFF},  // R1
    {4'd1,  4'd3, 32'hFFFF0000, 4'd3, 32'hFFFF0000},  // R1
    {4'd13, 4'd4, 32'hA5A5A5A5, 4'd4, 32'hA5A5A5A5},  // R13
    {4'd1,  4'd5, 32'hFFFFFFFF, 4'd5, 32'hFFFFFFFF},  // R1
    {4'd4,  4'd1, 32'h80000001, 4'd0, 32'h80000001},  // R4
    {4'd4,  4'd1, 32'h00010000, 4'd1, 32'h80010001},  // R4
    {4'd10, 4'd6, 32'hFFFFFFFF, 4'd6, 32'h80000001},  // R10
    {4'd5,  4'd0, 32'h00000001, 4'd0, 32'h80010000},  // R5
    {4'd9,  4'd8, 32'hFFFFFFFF, 4'd8, 32'hFFFFFFFD},  // R9
    {4'd7,  4'd8, 32'h00010000, 4'd7, 32'h00013E00},  // R7
    {4'd8,  4'd8, 32'h00010001, 4'd7, 32'h00010000},  // R8
    {4'd10, 4'd7, 32'hDEAD0000, 4'd7, 32'h00010000},  // R10
    {4'd10, 4'd9, 32'hFFFFFFFF, 4'd0, 32'h80010000},  // R10
    {4'd8,  4'd2, 32'hFFFFFFFF, 4'd7, 32'h00010000},  // R8
    {4'd9,  4'd8, 32'h00010003, 4'd8, 32'h00010001},  // R9
    {4'd7,  4'd8, 32'h00010000, 4'd7, 32'h00012000}   // R7
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    irq_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    do_reset();
    for (int a = 0; a <= 8; a++) begin
      rd(4'(a), v);
      chk($sformatf("R11 reset addr %0d", a), v, 32'h0);
    end
    chk("R11 reset irq_norm", {31'b0, irq_norm}, 32'h0);
    chk("R11 reset irq_crit", {31'b0, irq_crit}, 32'h0);

    for (int k = 0; k < 16; k++) begin
      wr(TBL[k][71:68], TBL[k][67:36]);
      rd(TBL[k][35:32], v);
      chk($sformatf("R%0d table entry %0d", TBL[k][75:72], k), v, TBL[k][31:0]);
    end

    addr = 4'd8; #1;
    chk("R12 no-vector config reads 0", rdata_nv, 32'h0);
    addr = 4'd7; #1;
    chk("R12 no-vector vector reads 0", rdata_nv, 32'h0);
    rd(4'd9, v);
    chk("R10 unmapped address reads 0", v, 32'h0);

    do_reset();
    wr(4'd5, 32'hFFFFFFFF);
    wr(4'd2, 32'hFFFFFFFF);
    @(negedge clk); irq_in[0] = 1'b1;
    @(negedge clk); irq_in[0] = 1'b0;
    @(negedge clk);
    rd(4'd0, v);
    chk("R2 edge pulse latched", v, 32'h80000000);
    chk("R6 normal request on", {31'b0, irq_norm}, 32'h1);
    wr(4'd0, 32'h80000000);
    rd(4'd0, v);
    chk("R5 edge bit cleared", v, 32'h0);
    @(negedge clk);
    irq_in[0] = 1'b1; addr = 4'd0; wdata = 32'h80000000; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    rd(4'd0, v);
    chk("R5 rise beats same-cycle clear", v, 32'h80000000);
    wr(4'd0, 32'h80000000);
    rd(4'd0, v);
    chk("R2 steady high does not re-set edge bit", v, 32'h0);

    wr(4'd1, 32'h80000000);
    wr(4'd3, 32'h80000000);
    chk("R6 critical request on", {31'b0, irq_crit}, 32'h1);
    chk("R6 normal request off", {31'b0, irq_norm}, 32'h0);
    rd(4'd7, v);
    chk("R7 vector from zero base", v, 32'h00003E00);
    wr(4'd0, 32'h80000000);
    chk("R6 critical request off", {31'b0, irq_crit}, 32'h0);
    rd(4'd7, v);
    chk("R9 vector zero when idle", v, 32'h0);
    irq_in = '0;

    wr(4'd5, 32'h0);
    @(negedge clk); irq_in[3] = 1'b1;
    @(negedge clk);
    rd(4'd0, v);
    chk("R3 level rise tracked", v, 32'h10000000);
    chk("R6 normal from level source", {31'b0, irq_norm}, 32'h1);
    wr(4'd0, 32'h10000000);
    rd(4'd0, v);
    chk("R5 clear keeps high level source", v, 32'h10000000);
    @(negedge clk); irq_in[3] = 1'b0;
    @(negedge clk);
    rd(4'd0, v);
    chk("R3 level fall tracked", v, 32'h0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule